// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block places the signals of a fixed set of on-chip digital peripherals onto a row of sixteen general-purpose pins. The pins are numbered 0 to 15: the low byte port supplies pins 0 to 7, and the high byte port supplies pins 8 to 15. Software chooses which peripherals are enabled and which pins are reserved (skipped). The block then decides, combinationally, which signal owns each pin. Signals are handed out in a fixed priority order, and each signal takes the lowest free pin. As a result, enabling a higher-priority peripheral shifts every lower-priority one to new pins.

Each owned pin carries its peripheral's output data and output enable, and the pin's input value is routed back to that peripheral. A pin that no signal owns behaves as GPIO and is driven from its port latch. Every pin has a push-pull or open-drain output mode. A separate single pin (the auxiliary GPIO) takes no part in the assignment. A global enable tri-states every output while it is clear. All configuration sits in registers on a simple synchronous bus. A per-pin status output reports the owner code of each pin.

Top module: `xbar_pin_router`

## Requirements
- R1: After reset, the register bus reads as follows: control reads 0, skip reads 0, mode reads 0, latch reads 16'hFFFF, and auxiliary reads 2'b01. Every `pad_oe` bit and `pad2_oe` are 0.
- R2: The bus has five writable registers, each written by `cfg_wr` with `cfg_addr` and read back combinationally on `cfg_rdata`. Address 0 is control. Address 1 is skip (1 = reserved). Address 2 is mode (1 = push-pull, 0 = open-drain). Address 3 is latch. Address 4 is auxiliary: bit0 is the latch and bit1 is the mode. Control bits 14:10 always read as 0.
- R3: While control bit15 (the global enable) is 0, all of the following hold: all `pad_oe` bits and `pad2_oe` are 0, every owner code is 16, and every peripheral input reads its idle value.
- R4: The enabled signals are handed out in ascending signal-index order, and each takes the lowest pin that is neither skipped nor already taken. The signal indices and their control bits are: UART tx 0 and rx 1 (bit0); SPI sck 2, miso 3, mosi 4 and nss 5 (bit1); SMBus sda 6 and scl 7 (bit2); comparator output 8 (bit3); clock output 9 (bit4); PCA channels 10 to 13 (bits 7:5); timer inputs 14 (bit8) and 15 (bit9). The owner code of each pin in `owner_o[5p+4:5p]` is the index of its signal.
- R5: A skipped pin is never owned, and assignment passes over it.
- R6: Enabled signals left over once the pins run out are not connected. A signal that is not connected reads idle on `periph_di`: 1 for signals 0 to 7, and 0 for signals 8 to 15.
- R7: An owned pin drives `pad_do` from `periph_do[s]`, and its raw output enable is `periph_oe[s]`.
- R8: An unowned pin has owner code 16. It drives `pad_do` from its latch bit, and its raw output enable is 1.
- R9: The value on `pad_oe` is the raw output enable ANDed with the global enable. In open-drain mode, it is additionally gated by the driven value being 0.
- R10: A connected signal reads `pad_di` of the pin it owns.
- R11: The PCA count field (control bits 7:5) enables channels 10 to 10+n-1. Counts above 4 behave as 4.
- R12: The auxiliary pin is always GPIO. `pad2_do` equals auxiliary bit0, and `pad2_oe` follows the R9 rule using auxiliary bit1 as its mode.
- R13: Address 5 reads `pad_di`. Address 6 reads `pad2_di` in bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| periph_do | input | 16 | Peripheral output data, by signal index |
| periph_oe | input | 16 | Peripheral output enable, by signal index |
| periph_di | output | 16 | Pin value returned to each peripheral signal |
| pad_di | input | 16 | Pin input values |
| pad_do | output | 16 | Pin output data |
| pad_oe | output | 16 | Pin output enable |
| pad2_di | input | 1 | Auxiliary pin input |
| pad2_do | output | 1 | Auxiliary pin output data |
| pad2_oe | output | 1 | Auxiliary pin output enable |
| owner_o | output | 80 | Owner code per pin, 5 bits each, 16 = GPIO |

## Verification
The assertions assume that every input is at a known level whenever it is sampled. They also assume that configuration changes arrive only through the register bus, one register per clock. The bench writes each register in its own bus cycle, and it changes the peripheral and pin inputs only on the falling clock edge. Random configurations have sparse skip masks so that pin exhaustion occurs only sometimes, and the PCA count ranges over the full 3-bit field. Directed cases cover the states the random draws rarely hit: the global enable clear, all sixteen signals on sixteen free pins, and heavy skipping.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int XB_NPIN = 16;
    localparam int XB_NSIG = 16;
    localparam int XB_DW   = 16;
    localparam int XB_AW   = 3;
    localparam int XB_OW   = $clog2(XB_NSIG + 1);
    localparam int XB_PW   = $clog2(XB_NPIN);
    localparam int XB_RW   = $clog2(((XB_NPIN > XB_NSIG) ? XB_NPIN : XB_NSIG) + 1);
    localparam int XB_NONE = XB_NSIG;
    localparam int XB_NPCA = 4;

    // register addresses
    localparam logic [XB_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [XB_AW-1:0] A_SKIP  = 3'd1;
    localparam logic [XB_AW-1:0] A_MODE  = 3'd2;
    localparam logic [XB_AW-1:0] A_LATCH = 3'd3;
    localparam logic [XB_AW-1:0] A_AUX   = 3'd4;
    localparam logic [XB_AW-1:0] A_PIN   = 3'd5;
    localparam logic [XB_AW-1:0] A_PIN2  = 3'd6;

    localparam logic [XB_DW-1:0] CTRL_MASK = 16'h83FF;
    localparam int               CTRL_GEN  = 15;
    // idle level seen by unconnected peripheral inputs
    localparam logic [XB_NSIG-1:0] XB_IDLE = 16'h00FF;

    // expand control bits into one enable per signal, in priority order
    function automatic logic [XB_NSIG-1:0] xb_sig_enable(input logic [XB_DW-1:0] c);
        logic [XB_NSIG-1:0] en;
        en        = '0;
        en[1:0]   = {2{c[0]}};
        en[5:2]   = {4{c[1]}};
        en[7:6]   = {2{c[2]}};
        en[8]     = c[3];
        en[9]     = c[4];
        for (int i = 0; i < XB_NPCA; i++) begin
            en[10+i] = (c[7:5] > 3'(i));
        end
        en[14]    = c[8];
        en[15]    = c[9];
        return en;
    endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [XB_AW-1:0]   addr,
    input  logic [XB_DW-1:0]   wdata,
    input  logic [XB_NPIN-1:0] pin_in,
    input  logic               pin2_in,
    output logic [XB_DW-1:0]   rdata,
    output logic [XB_DW-1:0]   ctrl_q,
    output logic [XB_NPIN-1:0] skip_q,
    output logic [XB_NPIN-1:0] mode_q,
    output logic [XB_NPIN-1:0] latch_q,
    output logic [1:0]         aux_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            skip_q  <= '0;
            mode_q  <= '0;
            latch_q <= '1;
            aux_q   <= 2'b01;
        end else if (wr) begin
            unique case (addr)
                A_CTRL:  ctrl_q  <= wdata & CTRL_MASK;
                A_SKIP:  skip_q  <= wdata[XB_NPIN-1:0];
                A_MODE:  mode_q  <= wdata[XB_NPIN-1:0];
                A_LATCH: latch_q <= wdata[XB_NPIN-1:0];
                A_AUX:   aux_q   <= wdata[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_SKIP:  rdata = XB_DW'(skip_q);
            A_MODE:  rdata = XB_DW'(mode_q);
            A_LATCH: rdata = XB_DW'(latch_q);
            A_AUX:   rdata = XB_DW'(aux_q);
            A_PIN:   rdata = XB_DW'(pin_in);
            A_PIN2:  rdata = XB_DW'(pin2_in);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/xbar_assign.sv
module xbar_assign
    import xbar_pkg::*;
(
    input  logic                     xen,
    input  logic [XB_NSIG-1:0]       sig_en,
    input  logic [XB_NPIN-1:0]       skip,
    output logic [XB_NPIN*XB_OW-1:0] owner_flat,
    output logic [XB_NSIG-1:0]       sig_conn,
    output logic [XB_NSIG*XB_PW-1:0] sig_pin_flat
);
    logic [XB_RW-1:0] prank [XB_NPIN];
    logic [XB_RW-1:0] srank [XB_NSIG];
    logic [XB_RW-1:0] pcnt, scnt;

    // rank of each free pin among free pins, and of each enabled signal
    always_comb begin
        pcnt = '0;
        for (int p = 0; p < XB_NPIN; p++) begin
            prank[p] = pcnt;
            pcnt     = pcnt + XB_RW'(!skip[p]);
        end
    end

    always_comb begin
        scnt = '0;
        for (int s = 0; s < XB_NSIG; s++) begin
            srank[s] = scnt;
            scnt     = scnt + XB_RW'(sig_en[s]);
        end
    end

    // a signal meets a pin when both have the same rank
    for (genvar p = 0; p < XB_NPIN; p++) begin : g_pin
        logic [XB_OW-1:0] own;
        always_comb begin
            own = XB_OW'(XB_NONE);
            for (int s = 0; s < XB_NSIG; s++) begin
                if (xen && sig_en[s] && !skip[p] && (srank[s] == prank[p]))
                    own = XB_OW'(s);
            end
        end
        assign owner_flat[p*XB_OW +: XB_OW] = own;
    end

    for (genvar s = 0; s < XB_NSIG; s++) begin : g_sig
        logic             hit;
        logic [XB_PW-1:0] where;
        always_comb begin
            hit   = 1'b0;
            where = '0;
            for (int p = 0; p < XB_NPIN; p++) begin
                if (xen && sig_en[s] && !skip[p] && (srank[s] == prank[p])) begin
                    hit   = 1'b1;
                    where = XB_PW'(p);
                end
            end
        end
        assign sig_conn[s]                      = hit;
        assign sig_pin_flat[s*XB_PW +: XB_PW]   = where;
    end
endmodule

// File: rtl/xbar_route.sv
module xbar_route
    import xbar_pkg::*;
(
    input  logic                     xen,
    input  logic [XB_NPIN*XB_OW-1:0] owner_flat,
    input  logic [XB_NSIG-1:0]       sig_conn,
    input  logic [XB_NSIG*XB_PW-1:0] sig_pin_flat,
    input  logic [XB_NSIG-1:0]       periph_do,
    input  logic [XB_NSIG-1:0]       periph_oe,
    input  logic [XB_NPIN-1:0]       latch,
    input  logic [XB_NPIN-1:0]       mode,
    input  logic [1:0]               aux,
    input  logic [XB_NPIN-1:0]       pad_di,
    output logic [XB_NPIN-1:0]       pad_do,
    output logic [XB_NPIN-1:0]       pad_oe,
    output logic                     pad2_do,
    output logic                     pad2_oe,
    output logic [XB_NSIG-1:0]       periph_di
);
    for (genvar p = 0; p < XB_NPIN; p++) begin : g_out
        logic [XB_OW-1:0] own;
        logic             raw_do, raw_oe;
        assign own = owner_flat[p*XB_OW +: XB_OW];
        always_comb begin
            raw_do = latch[p];
            raw_oe = 1'b1;
            for (int s = 0; s < XB_NSIG; s++) begin
                if (own == XB_OW'(s)) begin
                    raw_do = periph_do[s];
                    raw_oe = periph_oe[s];
                end
            end
        end
        assign pad_do[p] = raw_do;
        assign pad_oe[p] = xen & raw_oe & (mode[p] | ~raw_do);
    end

    for (genvar s = 0; s < XB_NSIG; s++) begin : g_in
        logic [XB_PW-1:0] pin;
        assign pin          = sig_pin_flat[s*XB_PW +: XB_PW];
        assign periph_di[s] = sig_conn[s] ? pad_di[pin] : XB_IDLE[s];
    end

    assign pad2_do = aux[0];
    assign pad2_oe = xen & (aux[1] | ~aux[0]);
endmodule

// File: rtl/xbar_pin_router.sv
module xbar_pin_router
    import xbar_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [XB_AW-1:0]         cfg_addr,
    input  logic [XB_DW-1:0]         cfg_wdata,
    output logic [XB_DW-1:0]         cfg_rdata,
    input  logic [XB_NSIG-1:0]       periph_do,
    input  logic [XB_NSIG-1:0]       periph_oe,
    output logic [XB_NSIG-1:0]       periph_di,
    input  logic [XB_NPIN-1:0]       pad_di,
    output logic [XB_NPIN-1:0]       pad_do,
    output logic [XB_NPIN-1:0]       pad_oe,
    input  logic                     pad2_di,
    output logic                     pad2_do,
    output logic                     pad2_oe,
    output logic [XB_NPIN*XB_OW-1:0] owner_o
);
    logic [XB_DW-1:0]         ctrl_q;
    logic [XB_NPIN-1:0]       skip_q, mode_q, latch_q;
    logic [1:0]               aux_q;
    logic                     xen;
    logic [XB_NSIG-1:0]       sig_en, sig_conn;
    logic [XB_NSIG*XB_PW-1:0] sig_pin_flat;

    xbar_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .pin_in  (pad_di),
        .pin2_in (pad2_di),
        .rdata   (cfg_rdata),
        .ctrl_q  (ctrl_q),
        .skip_q  (skip_q),
        .mode_q  (mode_q),
        .latch_q (latch_q),
        .aux_q   (aux_q)
    );

    assign xen    = ctrl_q[CTRL_GEN];
    assign sig_en = xb_sig_enable(ctrl_q);

    xbar_assign u_assign (
        .xen          (xen),
        .sig_en       (sig_en),
        .skip         (skip_q),
        .owner_flat   (owner_o),
        .sig_conn     (sig_conn),
        .sig_pin_flat (sig_pin_flat)
    );

    xbar_route u_route (
        .xen          (xen),
        .owner_flat   (owner_o),
        .sig_conn     (sig_conn),
        .sig_pin_flat (sig_pin_flat),
        .periph_do    (periph_do),
        .periph_oe    (periph_oe),
        .latch        (latch_q),
        .mode         (mode_q),
        .aux          (aux_q),
        .pad_di       (pad_di),
        .pad_do       (pad_do),
        .pad_oe       (pad_oe),
        .pad2_do      (pad2_do),
        .pad2_oe      (pad2_oe),
        .periph_di    (periph_di)
    );
endmodule

// File: rtl/xbar_pin_router_chk.sv
module xbar_pin_router_chk
    import xbar_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     xen,
    input logic [XB_DW-1:0]         ctrl_q,
    input logic [XB_NPIN-1:0]       skip_q,
    input logic [XB_NPIN-1:0]       mode_q,
    input logic [XB_NPIN-1:0]       latch_q,
    input logic [XB_NPIN-1:0]       pad_do,
    input logic [XB_NPIN-1:0]       pad_oe,
    input logic                     pad2_oe,
    input logic [XB_NPIN*XB_OW-1:0] owner_o
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == '0 && skip_q == '0 && pad_oe == '0));

    p_off_tristate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !xen |-> (pad_oe == '0 && !pad2_oe));

    for (genvar p = 0; p < XB_NPIN; p++) begin : g_pchk
        p_skip_unowned_r5: assert property (@(posedge clk) disable iff (!rst_n)
            skip_q[p] |-> (owner_o[p*XB_OW +: XB_OW] == XB_OW'(XB_NONE)));
        p_open_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[p] && !mode_q[p]) |-> !pad_do[p]);
        p_gpio_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_o[p*XB_OW +: XB_OW] == XB_OW'(XB_NONE)) |-> (pad_do[p] == latch_q[p]));
    end

    for (genvar s = 0; s < XB_NSIG; s++) begin : g_schk
        logic [XB_NPIN-1:0] hits;
        always_comb begin
            for (int p = 0; p < XB_NPIN; p++)
                hits[p] = (owner_o[p*XB_OW +: XB_OW] == XB_OW'(s));
        end
        p_single_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hits) <= 1);
    end
endmodule

bind xbar_pin_router xbar_pin_router_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .xen     (xen),
    .ctrl_q  (ctrl_q),
    .skip_q  (skip_q),
    .mode_q  (mode_q),
    .latch_q (latch_q),
    .pad_do  (pad_do),
    .pad_oe  (pad_oe),
    .pad2_oe (pad2_oe),
    .owner_o (owner_o)
);

// File: tb/xbar_pin_router_bench.sv
module xbar_pin_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] periph_do = '0, periph_oe = '0, periph_di;
    logic [15:0] pad_di = '0, pad_do, pad_oe;
    logic        pad2_di = 1'b0, pad2_do, pad2_oe;
    logic [79:0] owner_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench copy of the configuration
    logic [15:0] m_ctrl, m_skip, m_mode, m_latch;
    logic [1:0]  m_aux;
    int          e_own [16];
    logic [15:0] e_do, e_oe, e_di;

    always #10 clk = ~clk;

    xbar_pin_router u_xbar_pin_router (.*);

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
        cfg_addr = a;
        #1;
        chk(req, 80'(cfg_rdata), 80'(exp));
    endtask

    function automatic logic [15:0] m_en(input logic [15:0] c);
        logic [15:0] e;
        int n;
        e = '0;
        if (c[0]) e[0] = 1; if (c[0]) e[1] = 1;
        for (int i = 2; i <= 5; i++) if (c[1]) e[i] = 1;
        if (c[2]) begin e[6] = 1; e[7] = 1; end
        e[8] = c[3];
        e[9] = c[4];
        n = int'(c[7:5]);
        if (n > 4) n = 4;
        for (int i = 0; i < n; i++) e[10+i] = 1;
        e[14] = c[8];
        e[15] = c[9];
        return e;
    endfunction

    task automatic model();
        int          ptr, pin_of [16];
        logic [15:0] en, conn;
        logic        d, o;
        en = m_en(m_ctrl);
        conn = '0;
        ptr = 0;
        for (int p = 0; p < 16; p++) e_own[p] = 16;
        for (int s = 0; s < 16; s++) pin_of[s] = 0;
        if (m_ctrl[15]) begin
            for (int s = 0; s < 16; s++) begin
                if (en[s]) begin
                    while (ptr < 16 && m_skip[ptr]) ptr++;
                    if (ptr < 16) begin
                        e_own[ptr] = s; pin_of[s] = ptr; conn[s] = 1; ptr++;
                    end
                end
            end
        end
        for (int p = 0; p < 16; p++) begin
            d = (e_own[p] == 16) ? m_latch[p] : periph_do[e_own[p]];
            o = (e_own[p] == 16) ? 1'b1 : periph_oe[e_own[p]];
            e_do[p] = d;
            e_oe[p] = m_ctrl[15] & o & (m_mode[p] | ~d);
        end
        for (int s = 0; s < 16; s++)
            e_di[s] = conn[s] ? pad_di[pin_of[s]] : (s < 8);
    endtask

    task automatic load_cfg();
        wr(3'd0, m_ctrl); wr(3'd1, m_skip); wr(3'd2, m_mode);
        wr(3'd3, m_latch); wr(3'd4, {14'd0, m_aux});
        m_ctrl = m_ctrl & 16'h83FF;
    endtask

    task automatic check_all(input string tag);
        logic [79:0] eo;
        model();
        #1;
        for (int p = 0; p < 16; p++) eo[p*5 +: 5] = 5'(e_own[p]);
        chk({tag, " R4 R5 owner"}, owner_o, eo);
        chk({tag, " R7 R8 pad_do"}, 80'(pad_do), 80'(e_do));
        chk({tag, " R9 R3 pad_oe"}, 80'(pad_oe), 80'(e_oe));
        chk({tag, " R10 R6 periph_di"}, 80'(periph_di), 80'(e_di));
        chk({tag, " R12 aux pin"}, 80'({pad2_do, pad2_oe}),
            80'({m_aux[0], m_ctrl[15] & (m_aux[1] | ~m_aux[0])}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, 16'h0000, "R1 ctrl");
        rd(3'd1, 16'h0000, "R1 skip");
        rd(3'd2, 16'h0000, "R1 mode");
        rd(3'd3, 16'hFFFF, "R1 latch");
        rd(3'd4, 16'h0001, "R1 aux");
        chk("R1 oe", 80'({pad_oe, pad2_oe}), 80'(0));

        // R2 read-back with masked control bits
        wr(3'd0, 16'hFFFF); rd(3'd0, 16'h83FF, "R2 ctrl mask");
        wr(3'd1, 16'hA5C3); rd(3'd1, 16'hA5C3, "R2 skip");
        wr(3'd1, 16'h0000);
        // R13 pin read-back
        pad_di = 16'h3C5A; pad2_di = 1'b1;
        rd(3'd5, 16'h3C5A, "R13 pins");
        rd(3'd6, 16'h0001, "R13 aux pin");

        // R3 global enable clear: everything enabled otherwise
        periph_do = 16'h0000; periph_oe = 16'hFFFF;
        m_ctrl = 16'h03FF; m_skip = 0; m_mode = 16'hFFFF; m_latch = 0; m_aux = 2'b10;
        load_cfg(); check_all("R3 off");

        // R4 all sixteen signals on sixteen free pins, R11 count 4
        m_ctrl = 16'h839F; load_cfg(); check_all("R4 R11 full");
        // R11 count 7 behaves as 4
        m_ctrl = 16'h83FF; load_cfg(); check_all("R11 clamp");
        // R11 count 2 shifts timers down
        m_ctrl = 16'h835F; load_cfg(); check_all("R11 two");
        // R5 R6 heavy skip exhausts pins
        m_skip = 16'hF0F0; load_cfg(); check_all("R5 R6 exhaust");
        // R4 priority shift: only low-priority signals, then add UART
        m_skip = 0; m_ctrl = 16'h8318; load_cfg(); check_all("R4 low only");
        m_ctrl = 16'h8319; load_cfg(); check_all("R4 shifted");
        // R9 open-drain on all pins, R8 GPIO latch
        m_mode = 0; m_latch = 16'h0F0F; periph_do = 16'hAAAA; load_cfg(); check_all("R9 R8 od");

        // random mix
        for (int v = 0; v < 300; v++) begin
            m_ctrl  = 16'($urandom);
            if ($urandom_range(7) != 0) m_ctrl[15] = 1'b1;
            m_skip  = 16'($urandom & $urandom & $urandom);
            m_mode  = 16'($urandom);
            m_latch = 16'($urandom);
            m_aux   = 2'($urandom);
            load_cfg();
            periph_do = 16'($urandom); periph_oe = 16'($urandom);
            pad_di = 16'($urandom);
            check_all("rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule